// File: doc/BRIEF.md
# Touch Panel Converter Serial Responder

This block is the digital serial side of a touch-panel analog-to-digital converter. A host drives an active-low select, a serial clock that idles low, and a serial data line. In each 24-clock frame the host first shifts in an 8-bit command, most significant bit first. The responder reads the start flag, the channel code, the resolution flag, the reference-mode flag and the two power bits from that command. It latches a 12-bit conversion value from one of its sample ports and returns it on the serial output. The analog converter and the panel biasing sit outside the block. They receive the decoded command through the `conv_*` outputs, and they deliver results on `x_sample` and `y_sample`.

All serial pins are oversampled by the system clock through a synchronizer, so the whole block runs in one clock domain. The returned value follows a single busy clock. Zeros pad the frame after it. A separate active-low pen interrupt follows a touch-detect input unless the last accepted command disabled it.

Top module: `touch_adc_resp`

## Requirements
- R1: After `sel_n` falls, the command byte is taken from `sdi` on rising `sclk` edges 1 to 8, first bit first. Its layout is: bit 7 start flag, bits 6:4 channel code, bit 3 resolution flag, bit 2 reference flag, bits 1:0 power bits.
- R2: A command whose start flag is 0 is ignored. `conv_start` does not pulse, the `conv_*` fields keep their values, and `sdo` reads 0 at every rising edge of that frame.
- R3: For an accepted command, `conv_start` pulses high for exactly one system clock after the 8th rising edge. The `conv_*` fields then take the command's fields: `conv_chan` gets the channel code, `conv_8bit` the resolution flag (1 means 8-bit), `conv_single` the reference flag (1 means single-ended, 0 differential), and `conv_pd` the power bits.
- R4: At the 8th rising edge, channel code 001 latches `x_sample` and code 101 latches `y_sample`. Any other code yields a result of 0. Sample-port changes after that edge do not alter the frame.
- R5: `sdo` changes only after falling `sclk` edges. It reads 0 at rising edges 1 to 9; edge 9 is the busy clock. In 12-bit mode, result bits 11 down to 0 are read at rising edges 10 to 21.
- R6: In 8-bit mode, result bits 11 down to 4 are read at rising edges 10 to 17, and `sdo` reads 0 from rising edge 18 to the end of the frame.
- R7: In 12-bit mode, `sdo` reads 0 at rising edges 22 to 24 and at any extra clocks before `sel_n` rises.
- R8: While `sel_n` is high, `sdo_en` is 0 (output released). Raising `sel_n` mid-frame aborts the frame without updating `conv_*`, and the next fall of `sel_n` starts again at clock 1.
- R9: `pen_int_n` is low exactly when `tp_touch` is high and the power bits of the last accepted command are not 11.
- R10: After reset, `conv_start` is 0, all `conv_*` fields are 0, and `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial result output |
| sdo_en | output | 1 | Output drive enable; the pad is high-impedance when 0 |
| x_sample | input | 12 | Conversion value for channel code 001 |
| y_sample | input | 12 | Conversion value for channel code 101 |
| tp_touch | input | 1 | Touch-detect input, high while touched |
| pen_int_n | output | 1 | Active-low pen interrupt |
| conv_start | output | 1 | One-clock pulse when a command is accepted |
| conv_chan | output | 3 | Channel code of the last accepted command |
| conv_8bit | output | 1 | Resolution flag of the last accepted command |
| conv_single | output | 1 | Reference flag of the last accepted command |
| conv_pd | output | 2 | Power bits of the last accepted command |

## Verification
The bench captures every `sdo` bit at the host's sampling instant and compares the frame with a bench-computed vector. A design one edge off would shift the result into the busy clock or the tail, and an 8-bit frame that leaked low-order bits would fail the padding check. Commands with a cleared start flag, unmapped channel codes and sample values changed after the latch point target designs that decode too early, latch too late or default to a live port. Frames aborted mid-command, over-long frames and power bits of 11 check that `conv_*` survives aborts, that the tail stays low and that the pen interrupt is masked.

// File: rtl/touch_adc_resp.sv
module touch_adc_resp #(
  parameter int SYNC_STAGES = 2,
  parameter int RES_W = 12,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_en,
  input  logic [RES_W-1:0] x_sample,
  input  logic [RES_W-1:0] y_sample,
  input  logic             tp_touch,
  output logic             pen_int_n,
  output logic             conv_start,
  output logic [2:0]       conv_chan,
  output logic             conv_8bit,
  output logic             conv_single,
  output logic [1:0]       conv_pd
);
  localparam int CMD_W = 8;
  localparam logic [4:0] FIRST_DATA = 5'(CMD_W + 1);
  localparam logic [4:0] LAST_HI = 5'(CMD_W + RES_W);
  localparam logic [4:0] LAST_LO = 5'(CMD_W + LOW_W);
  localparam logic [2:0] CH_X = 3'b001;
  localparam logic [2:0] CH_Y = 3'b101;

  logic [2:0] sync_q [SYNC_STAGES];
  logic sel_s, sclk_s, sdi_s, sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b100;
      sclk_d <= 1'b0;
    end else begin
      sync_q[0] <= {sel_n, sclk, sdi};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      sclk_d <= sclk_s;
    end
  end

  assign {sel_s, sclk_s, sdi_s} = sync_q[SYNC_STAGES-1];

  logic rise, fall;
  assign rise = sclk_s & ~sclk_d & ~sel_s;
  assign fall = ~sclk_s & sclk_d & ~sel_s;

  logic [4:0]       cnt;
  logic [CMD_W-1:0] cmd;
  logic [CMD_W-1:0] cmd_next;
  logic [RES_W-1:0] res;
  logic             frame_ok;
  logic             sdo_q;
  logic             en_q;

  assign cmd_next = {cmd[CMD_W-2:0], sdi_s};

  logic [4:0]       bit_idx;
  logic [RES_W-1:0] res_sh;
  logic [4:0]       last_cnt;
  logic             in_data;
  assign bit_idx  = LAST_HI - cnt;
  assign res_sh   = res >> bit_idx;
  assign last_cnt = conv_8bit ? LAST_LO : LAST_HI;
  assign in_data  = frame_ok && cnt >= FIRST_DATA && cnt <= last_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cmd <= '0; res <= '0; frame_ok <= 1'b0;
      sdo_q <= 1'b0; en_q <= 1'b0; conv_start <= 1'b0;
      conv_chan <= '0; conv_8bit <= 1'b0; conv_single <= 1'b0; conv_pd <= '0;
    end else begin
      conv_start <= 1'b0;
      en_q <= ~sel_s;
      if (sel_s) begin
        cnt <= '0; cmd <= '0; frame_ok <= 1'b0; sdo_q <= 1'b0;
      end else begin
        if (rise) begin
          if (cnt != 5'd31) cnt <= cnt + 5'd1;
          if (cnt < 5'(CMD_W)) cmd <= cmd_next;
          if (cnt == 5'(CMD_W - 1) && cmd_next[CMD_W-1]) begin
            frame_ok    <= 1'b1;
            conv_start  <= 1'b1;
            conv_chan   <= cmd_next[6:4];
            conv_8bit   <= cmd_next[3];
            conv_single <= cmd_next[2];
            conv_pd     <= cmd_next[1:0];
            res <= (cmd_next[6:4] == CH_X) ? x_sample :
                   (cmd_next[6:4] == CH_Y) ? y_sample : '0;
          end
        end
        if (fall) sdo_q <= in_data & res_sh[0];
      end
    end
  end

  assign sdo       = sdo_q;
  assign sdo_en    = en_q;
  assign pen_int_n = ~(tp_touch & (conv_pd != 2'b11));

  p_busy_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cnt == 5'(CMD_W)) |=> !sdo_q);
  p_tail_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cnt > LAST_HI) |=> !sdo_q);
  p_low_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && conv_8bit && cnt > LAST_LO) |=> !sdo_q);
  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt == 5'(CMD_W - 1) && !cmd[CMD_W-2]) |=> (!conv_start && $stable(conv_chan) && $stable(conv_pd)));
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (!sdo_en && cnt == 5'd0 && !sdo));
  p_pen_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_touch |-> pen_int_n);
endmodule

// File: tb/touch_adc_resp_tb.sv
module touch_adc_resp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0, tp_touch = 1'b0;
  logic [11:0] x_sample = '0, y_sample = '0;
  logic sdo, sdo_en, pen_int_n, conv_start, conv_8bit, conv_single;
  logic [2:0] conv_chan;
  logic [1:0] conv_pd;

  always #2 clk = ~clk;

  touch_adc_resp dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .x_sample(x_sample), .y_sample(y_sample),
    .tp_touch(tp_touch), .pen_int_n(pen_int_n), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_8bit(conv_8bit), .conv_single(conv_single),
    .conv_pd(conv_pd));

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 1'b0;
  logic [2:0] m_chan = '0;
  logic m_8bit = 1'b0, m_single = 1'b0;
  logic [1:0] m_pd = '0;

  always @(posedge clk) if (conv_start) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [7:0] c, input logic [11:0] x, input logic [11:0] y);
    logic [11:0] r;
    logic [31:0] v;
    v = '0;
    r = !c[7] ? 12'd0 : (c[6:4] == 3'b001) ? x : (c[6:4] == 3'b101) ? y : 12'd0;
    for (int n = 10; n <= 21; n++)
      if (!(c[3] && n > 17)) v[32-n] = r[21-n];
    return v;
  endfunction

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] c, input int nclk, input logic [11:0] x,
                           input logic [11:0] y, output logic [31:0] cap);
    cap = '0;
    x_sample = x; y_sample = y; pulses = 0;
    @(negedge clk); sel_n = 1'b0;
    for (int n = 1; n <= nclk; n++) begin
      sdi = (n <= 8) ? c[8-n] : 1'b0;
      half();
      cap[32-n] = sdo;
      if (n == 1) chk("R8 enable while selected", {31'd0, sdo_en}, 32'd1);
      sclk = 1'b1;
      half();
      if (n == 9) begin x_sample = ~x; y_sample = ~y; end
      sclk = 1'b0;
    end
    half();
    sel_n = 1'b1;
    half();
    if (c[7] && nclk >= 8) begin
      m_chan = c[6:4]; m_8bit = c[3]; m_single = c[2]; m_pd = c[1:0];
    end
  endtask

  task automatic check_cfg(input string req, input int exp_pulses);
    chk(req, {22'd0, conv_chan, conv_8bit, conv_single, conv_pd, 3'd0}, {22'd0, m_chan, m_8bit, m_single, m_pd, 3'd0});
    chk(req, pulses, exp_pulses);
  endtask

  task automatic check_pen();
    for (int t = 0; t < 2; t++) begin
      tp_touch = t[0];
      repeat (2) @(negedge clk);
      chk("R9 pen interrupt", {31'd0, pen_int_n}, {31'd0, ~(tp_touch && m_pd != 2'b11)});
    end
  endtask

  task automatic full_check(input logic [7:0] c, input int nclk, input logic [11:0] x, input logic [11:0] y, input string req);
    logic [31:0] cap;
    run_frame(c, nclk, x, y, cap);
    chk(req, cap, exp_frame(c, x, y));
    check_cfg("R3 decoded fields", c[7] ? 1 : 0);
    chk("R8 released after frame", {31'd0, sdo_en}, 32'd0);
  endtask

  initial begin
    logic [31:0] cap;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    chk("R10 reset sdo_en", {31'd0, sdo_en}, 32'd0);
    chk("R10 reset fields", {25'd0, conv_start, conv_chan, conv_8bit, conv_single, conv_pd}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pen();

    full_check(8'b1001_0000, 24, 12'hA5C, 12'h3F1, "R5 x channel 12-bit");
    full_check(8'b1101_0000, 24, 12'hFFF, 12'h9E7, "R5 y channel 12-bit");
    full_check(8'b1001_1000, 24, 12'hFFF, 12'h000, "R6 8-bit padding");
    full_check(8'b0101_1111, 24, 12'hFFF, 12'hFFF, "R2 start flag clear");
    full_check(8'b1011_0100, 24, 12'hFFF, 12'hFFF, "R4 unmapped channel zero");
    full_check(8'b1101_0011, 28, 12'h000, 12'hFFF, "R7 extra clocks low");
    check_pen();
    full_check(8'b1001_0001, 24, 12'h801, 12'h000, "R1 command layout");
    check_pen();

    x_sample = 12'hFFF; pulses = 0;
    @(negedge clk); sel_n = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      sdi = n[0]; half(); sclk = 1'b1; half(); sclk = 1'b0;
    end
    half(); sel_n = 1'b1; half();
    check_cfg("R8 aborted frame keeps fields", 0);
    full_check(8'b1001_0010, 24, 12'h5A5, 12'h000, "R8 frame after abort");

    for (int k = 0; k < 40; k++) begin
      logic [7:0] c;
      logic [11:0] x, y;
      c = 8'($urandom);
      if (k % 5 != 0) c[7] = 1'b1;
      if (k % 3 == 0) c[6:4] = 3'b001;
      else if (k % 3 == 1) c[6:4] = 3'b101;
      x = 12'($urandom); y = 12'($urandom);
      full_check(c, 24, x, y, c[3] ? "R6 random 8-bit frame" : "R5 random 12-bit frame");
      if (k % 8 == 0) check_pen();
    end

    run_frame(8'b1101_0000, 24, 12'h000, 12'hC3A, cap);
    chk("R4 latch ignores later sample change", cap, exp_frame(8'b1101_0000, 12'h000, 12'hC3A));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule